// File: doc/BRIEF.md
# Embedded-Clock Framing Serializer

This block turns parallel data words into a single serial bitstream that carries its own timing. Every word leaves as a frame of data width plus two bit times: a start slot that is always high, the data bits least significant first, and a stop slot that is always low. Because a stop slot is always followed at once by the next start slot, every frame boundary carries a low-to-high edge that a receiver can lock onto. The block runs entirely in the serial bit clock domain, so the parallel word rate is the bit rate divided by the frame length (12 for the default 10-bit word).

A receiver that has not yet locked drives the sync request high. The serializer then replaces data frames with a training square wave: half a frame high, half a frame low. This keeps the boundary edge in the same place. Sync request is looked at only on frame boundaries, so no frame is ever cut short. A power-down input forces the line into a quiet, disabled state at once and rewinds the slot counter. The next frame then starts on the first edge after power-down is released.

The controller is a three-state machine. OFF is the reset and power-down state. TRAIN sends the square wave. DATA sends the captured word. The transitions are as follows. Any state goes to OFF while power-down is high. OFF goes to TRAIN or DATA on the first edge with power-down low, depending on sync request. At each frame boundary, TRAIN goes to DATA when sync request is low, and DATA goes to TRAIN when sync request is high. Otherwise the state holds.

Top module: `frame_serializer`

## Requirements
- R1: While reset is active, and on every clock after an edge at which power-down was high, `ser_out` is 0, `drv_en` is 0 and the slot counter rests on the last slot (state OFF).
- R2: With power-down low, the slot counter steps 0,1,...,11 and wraps, so consecutive `word_accept` pulses in uninterrupted operation are exactly 12 clocks apart.
- R3: In a data frame, slot 0 (the start bit) drives `ser_out` = 1.
- R4: In a data frame, slots 1 to 10 drive the captured word's bits 0 to 9 in that order (LSB first).
- R5: Slot 11 (the stop bit) drives `ser_out` = 0 in data and training frames, so each boundary shows a low-to-high edge.
- R6: In a training frame, slots 0 to 5 drive 1 and slots 6 to 11 drive 0.
- R7: A change of `sync_req` anywhere other than the last slot has no effect on the frame in progress.
- R8: The first frame after `sync_req` is seen low at a boundary carries the `word_in` value present at that boundary.
- R9: `word_accept` is high only while the counter is on the last slot with power-down and `sync_req` both low, and `word_in` is captured at the clock edge that ends that cycle. It never stays high for two cycles in a row.
- R10: Raising power-down mid-frame aborts the frame at the next edge. After release, a new frame starts on the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down: line quiet, driver disabled, counter rewound |
| sync_req | input | 1 | Receiver not locked: send training frames |
| word_in | input | DATA_W | Parallel word, captured on the edge after `word_accept` |
| word_accept | output | 1 | This cycle's edge takes `word_in` |
| ser_out | output | 1 | Serial line (0 when disabled) |
| drv_en | output | 1 | Line driver enable; low means tristate |

## Verification
`word_accept` is combinational on the present slot and inputs, so it is checked in the same cycle, a delta after the inputs change. Every serial bit comes from registered state, so the slot driven in response to the inputs before an edge appears one edge later, and the bench compares it at the falling edge that follows. The bench keeps its own slot, mode and word model, advances it at each rising edge with the inputs it drove, and compares on every clock. Whole data frames are also reassembled from the line and compared with the word that was offered at the boundary.

// File: rtl/fser_pkg.sv
package fser_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_TRAIN = 2'd1,
        ST_DATA  = 2'd2
    } fser_state_t;

endpackage

// File: rtl/fser_slot_counter.sv
module fser_slot_counter #(
    parameter int FRAME_LEN = 12,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    output logic [CNT_W-1:0] slot,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    assign at_last = (slot == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= LAST;
        end else if (pwr_dn) begin
            slot <= LAST;
        end else if (at_last) begin
            slot <= '0;
        end else begin
            slot <= slot + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fser_frame_fsm.sv
module fser_frame_fsm
    import fser_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              at_last,
    input  logic              sync_req,
    input  logic [DATA_W-1:0] word_in,
    output fser_state_t       state,
    output logic [DATA_W-1:0] hold_word,
    output logic              take
);
    fser_state_t state_nx;

    // boundary decision: leaves a frame only on the last slot
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   state_nx = sync_req ? ST_TRAIN : ST_DATA;
            ST_TRAIN: if (at_last && !sync_req) state_nx = ST_DATA;
            ST_DATA:  if (at_last && sync_req)  state_nx = ST_TRAIN;
            default:  state_nx = ST_OFF;
        endcase
        if (pwr_dn) state_nx = ST_OFF;
    end

    assign take = at_last && !pwr_dn && !sync_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            hold_word <= '0;
        end else begin
            state <= state_nx;
            if (take) hold_word <= word_in;
        end
    end
endmodule

// File: rtl/fser_bit_mux.sv
module fser_bit_mux
    import fser_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int FRAME_LEN = DATA_W + 2,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  fser_state_t       state,
    input  logic [CNT_W-1:0]  slot,
    input  logic [DATA_W-1:0] hold_word,
    output logic              ser_bit,
    output logic              drv_en
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(FRAME_LEN / 2);

    logic [DATA_W-1:0] shifted;

    assign shifted = hold_word >> (slot - CNT_W'(1));

    always_comb begin
        ser_bit = 1'b0;
        drv_en  = 1'b1;
        unique case (state)
            ST_OFF: begin
                ser_bit = 1'b0;
                drv_en  = 1'b0;
            end
            ST_TRAIN: ser_bit = (slot < HALF);
            ST_DATA: begin
                if (slot == '0)        ser_bit = 1'b1;
                else if (slot == LAST) ser_bit = 1'b0;
                else                   ser_bit = shifted[0];
            end
            default: begin
                ser_bit = 1'b0;
                drv_en  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import fser_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              sync_req,
    input  logic [DATA_W-1:0] word_in,
    output logic              word_accept,
    output logic              ser_out,
    output logic              drv_en
);
    localparam int FRAME_LEN = DATA_W + 2;
    localparam int CNT_W     = $clog2(FRAME_LEN);

    logic [CNT_W-1:0]  slot;
    logic              at_last;
    fser_state_t       state;
    logic [DATA_W-1:0] hold_word;

    fser_slot_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_dn  (pwr_dn),
        .slot    (slot),
        .at_last (at_last)
    );

    fser_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .at_last   (at_last),
        .sync_req  (sync_req),
        .word_in   (word_in),
        .state     (state),
        .hold_word (hold_word),
        .take      (word_accept)
    );

    fser_bit_mux #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_mux (
        .state     (state),
        .slot      (slot),
        .hold_word (hold_word),
        .ser_bit   (ser_out),
        .drv_en    (drv_en)
    );
endmodule

// File: rtl/fser_checker.sv
module fser_checker
    import fser_pkg::*;
#(
    parameter int FRAME_LEN = 12,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn,
    input logic             sync_req,
    input logic             word_accept,
    input logic             ser_out,
    input logic             drv_en,
    input logic [CNT_W-1:0] slot,
    input fser_state_t      state
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    assert_quiet_after_pd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!drv_en && !ser_out && slot == LAST));

    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);

    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn && slot == LAST) |=> slot == '0);

    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn && slot != LAST) |=> slot == $past(slot) + CNT_W'(1));

    assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_accept |=> ser_out);

    assert_stop_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_accept |-> !ser_out);

    assert_no_mid_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn && slot != LAST) |=> $stable(state));

    assert_single_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_accept |=> !word_accept);

    assert_accept_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_accept |-> (!pwr_dn && !sync_req));
endmodule

bind frame_serializer fser_checker #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/frame_serializer_test.sv
module frame_serializer_test;
    localparam int DW = 10;
    localparam int FL = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_dn = 1'b0;
    logic          sync_req = 1'b0;
    logic [DW-1:0] word_in = '0;
    logic          word_accept;
    logic          ser_out;
    logic          drv_en;

    int checks = 0;
    int errors = 0;
    string ctx = "";

    // behavioural reference: mode 0 off, 1 training, 2 data
    int m_pos  = FL - 1;
    int m_mode = 0;
    int m_word = 0;
    int cyc = 0;
    int last_acc = -1;
    bit period_on = 1'b0;
    int rx_bits = 0;

    frame_serializer #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .sync_req(sync_req),
        .word_in(word_in), .word_accept(word_accept), .ser_out(ser_out), .drv_en(drv_en)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_bit();
        if (m_mode == 0) return 0;
        if (m_mode == 1) return (m_pos < FL / 2) ? 1 : 0;
        if (m_pos == 0) return 1;
        if (m_pos == FL - 1) return 0;
        return (m_word >> (m_pos - 1)) & 1;
    endfunction

    function automatic string bit_tag();
        if (ctx != "") return ctx;
        if (m_mode == 0) return "R1";
        if (m_mode == 1) return (m_pos == FL - 1) ? "R5" : "R6";
        if (m_pos == 0) return "R3";
        if (m_pos == FL - 1) return "R5";
        return "R4";
    endfunction

    task automatic step(input bit pd, input bit sr, input int w);
        int exp_acc;
        pwr_dn = pd;
        sync_req = sr;
        word_in = DW'(w);
        #1;
        exp_acc = (!pd && m_pos == FL - 1 && !sr) ? 1 : 0;
        check("R9 word_accept", int'(word_accept), exp_acc);
        if (word_accept && period_on && last_acc >= 0)
            check("R2 accept spacing", cyc - last_acc, FL);
        if (word_accept) last_acc = cyc;
        @(posedge clk);
        cyc++;
        if (pd) begin
            m_pos = FL - 1;
            m_mode = 0;
        end else if (m_pos == FL - 1) begin
            m_pos = 0;
            m_mode = sr ? 1 : 2;
            if (!sr) m_word = w;
        end else begin
            m_pos++;
        end
        @(negedge clk);
        check({bit_tag(), " ser_out"}, int'(ser_out), exp_bit());
        check({bit_tag(), " drv_en"}, int'(drv_en), (m_mode != 0) ? 1 : 0);
        if (m_pos >= 1 && m_pos <= DW) rx_bits = rx_bits | (int'(ser_out) << (m_pos - 1));
    endtask

    // one aligned frame with the line reassembled and compared
    task automatic frame(input bit sr, input int w, input string tag);
        rx_bits = 0;
        for (int i = 0; i < FL; i++) step(1'b0, sr, w);
        if (!sr) check({tag, " frame word"}, rx_bits, w);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pwr_dn = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset ser_out", int'(ser_out), 0);
        check("R1 reset drv_en", int'(drv_en), 0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 0);

        // training frames while receiver unlocked (R6)
        for (int f = 0; f < 3; f++) frame(1'b1, 0, "R6");

        // sync drops mid-frame: no effect until boundary (R7)
        ctx = "R7";
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 'h0F0);
        for (int i = 0; i < FL - 5; i++) step(1'b0, 1'b0, 'h0F0);
        ctx = "";

        // first data frame after release carries boundary word (R8)
        frame(1'b0, 'h2C5, "R8");

        // assorted patterns, uninterrupted, with spacing check (R2, R3, R4, R5)
        period_on = 1'b1;
        frame(1'b0, 'h3FF, "R4");
        frame(1'b0, 'h000, "R4");
        frame(1'b0, 'h155, "R4");
        frame(1'b0, 'h2AA, "R4");
        frame(1'b0, 'h001, "R4");
        frame(1'b0, 'h200, "R4");
        period_on = 1'b0;

        // sync rises mid data frame: frame completes (R7)
        ctx = "R7";
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 'h11);
        for (int i = 0; i < FL - 6; i++) step(1'b0, 1'b1, 'h11);
        ctx = "";
        frame(1'b1, 'h11, "R6");
        frame(1'b1, 'h11, "R6");
        frame(1'b0, 'h1A3, "R8");

        // power-down mid-frame, then immediate restart (R10)
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 'h0C3);
        ctx = "R10";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 'h0C3);
        ctx = "";
        frame(1'b0, 'h35A, "R10");
        frame(1'b0, 'h0A5, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule